// File: doc/BRIEF.md
# E1 Timeslot-0 Spare-Bit Transmit Buffer

This block supplies the national spare bits Sa4 to Sa8 that the framer places in timeslot 0 of the frames without frame alignment in an E1 multiframe. The host loads five 8-bit registers, one for each spare-bit position. The block keeps a shadow copy of them, and that copy drives the line for a whole multiframe. The framer's timeslot-0 builder asks for one bit at a time. It presents the bit position it is building. The block answers with the bit value and a valid flag for the current frame.

The block counts frames from a per-frame strobe. When a strobe arrives while the count is 15, the multiframe begins. At that point the host registers are copied into the shadow and an interrupt flag is raised, which tells the host to load the data for the following multiframe. If the host writes nothing, the same contents go out again. Each register's eight bits are spread over the eight odd frames, least significant bit first.

Top module: `sa_tx_buffer`

## Requirements
- R1: After reset the host registers and the shadow are 0x00, `irq` is 0, and `frame_num` is 15. The first `frame_strobe` therefore begins a multiframe.
- R2: A write with `wr_sel` from 0 to 4 loads the register for Sa4 to Sa8 respectively. A write with `wr_sel` from 5 to 7 has no effect.
- R3: The shadow changes only at a multiframe begin, which is a `frame_strobe` while `frame_num` is 15. At that point it takes all five host registers. Writes made at any other time do not reach the output until the next multiframe begin.
- R4: A host write in the same cycle as a multiframe begin is included in the shadow copy.
- R5: In frame 2k+1 (k from 0 to 7) at `sa_pos` = 4+j (j from 0 to 4), `sa_bit` equals bit k of the shadow copy of register j.
- R6: `sa_valid` and `sa_bit` are 0 in even frames and for any `sa_pos` outside 4 to 8. Bit positions are numbered 1 to 8 within timeslot 0.
- R7: `sa_valid` and `sa_bit` are 0 unless `xfs_en` and `sa_access_en` are both 1 and `ts0_transp` is 0.
- R8: A multiframe begin with `xfs_en` and `sa_access_en` both 1 sets `irq` in the following cycle. `irq` stays set until an `irq_clr` pulse, and a set in the same cycle as a clear wins.
- R9: If the host does not write between two multiframe begins, the following multiframe carries the same bits again.
- R10: `frame_num` rises by one in the cycle after each `frame_strobe`, wrapping from 15 to 0, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select, 0 to 4 for Sa4 to Sa8 |
| wr_data | input | 8 | Host write data |
| irq_clr | input | 1 | Host clear of the interrupt flag |
| xfs_en | input | 1 | Transmit spare-bit enable |
| sa_access_en | input | 1 | Spare-bit register access enable |
| ts0_transp | input | 1 | Any timeslot-0 transparent mode active |
| frame_strobe | input | 1 | One-cycle pulse at the start of each frame |
| sa_pos | input | 4 | Timeslot-0 bit position being built, 1 to 8 |
| frame_num | output | 4 | Current frame number in the multiframe |
| sa_bit | output | 1 | Spare-bit value for this frame and position |
| sa_valid | output | 1 | `sa_bit` should be inserted |
| irq | output | 1 | Multiframe-begin interrupt flag |

## Verification
A wrong frame count shows up on `frame_num` in the cycle after the strobe. It also moves every spare bit into the wrong frame within the same multiframe. A shadow that loads at the wrong time, or misses a coincident write, changes `sa_bit` at the first odd frame of the following multiframe. This is at most 17 strobes after the faulty event. The bench sweeps every bit position in every frame, across several register patterns and all enable combinations, so a fault in the bit index or the register index shows within one multiframe.

// File: rtl/sa_tx_pkg.sv
package sa_tx_pkg;
  localparam int SA_NUM_DEF   = 5;
  localparam int SA_W_DEF     = 8;
  localparam int SA_FIRST     = 4;

  // frame number -> bit index inside a spare-bit register (odd frames only)
  function automatic int unsigned frame_to_bit(input int unsigned frame);
    return frame >> 1;
  endfunction

  // timeslot-0 bit position -> register index; returns SA_NUM_DEF when out of range
  function automatic int unsigned pos_to_reg(input int unsigned pos);
    if (pos < SA_FIRST || pos >= SA_FIRST + SA_NUM_DEF) return SA_NUM_DEF;
    return pos - SA_FIRST;
  endfunction
endpackage

// File: rtl/sa_frame_ctr.sv
module sa_frame_ctr #(
  parameter int FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [FRM_W-1:0] frame_num,
  output logic             mf_begin
);
  localparam logic [FRM_W-1:0] LAST = '1;

  assign mf_begin = strobe && (frame_num == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      frame_num <= LAST;
    else if (strobe) frame_num <= frame_num + 1'b1;
  end
endmodule

// File: rtl/sa_regfile.sv
module sa_regfile #(
  parameter int N     = 5,
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [W-1:0]       wr_data,
  input  logic               copy,
  output logic [N-1:0][W-1:0] shadow_q
);
  logic [N-1:0][W-1:0] host_q;
  logic [N-1:0][W-1:0] host_nxt;

  for (genvar g = 0; g < N; g++) begin : g_reg
    assign host_nxt[g] = (wr_en && wr_sel == SEL_W'(g)) ? wr_data : host_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        host_q[g]   <= '0;
        shadow_q[g] <= '0;
      end else begin
        host_q[g] <= host_nxt[g];
        if (copy) shadow_q[g] <= host_nxt[g];
      end
    end
  end
endmodule

// File: rtl/sa_irq_flag.sv
module sa_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/sa_bit_mux.sv
module sa_bit_mux #(
  parameter int N     = 5,
  parameter int W     = 8,
  parameter int FRM_W = 4,
  parameter int POS_W = 4
) (
  input  logic [N-1:0][W-1:0] shadow,
  input  logic [FRM_W-1:0]    frame_num,
  input  logic [POS_W-1:0]    sa_pos,
  input  logic                active,
  output logic                sa_bit,
  output logic                sa_valid
);
  import sa_tx_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;

  int unsigned reg_idx;
  int unsigned bit_idx;
  logic        pos_ok;

  always_comb begin
    reg_idx  = pos_to_reg(int'(sa_pos));
    bit_idx  = frame_to_bit(int'(frame_num));
    pos_ok   = reg_idx < N;
    sa_valid = active && pos_ok && frame_num[0];
    sa_bit   = 1'b0;
    if (sa_valid) sa_bit = shadow[reg_idx[IDX_W-1:0]][bit_idx[BIT_W-1:0]];
  end
endmodule

// File: rtl/sa_tx_buffer.sv
module sa_tx_buffer #(
  parameter int SA_NUM = sa_tx_pkg::SA_NUM_DEF,
  parameter int SA_W   = sa_tx_pkg::SA_W_DEF,
  parameter int POS_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(SA_NUM)-1:0] wr_sel,
  input  logic [SA_W-1:0]           wr_data,
  input  logic                      irq_clr,
  input  logic                      xfs_en,
  input  logic                      sa_access_en,
  input  logic                      ts0_transp,
  input  logic                      frame_strobe,
  input  logic [POS_W-1:0]          sa_pos,
  output logic [$clog2(2*SA_W)-1:0] frame_num,
  output logic                      sa_bit,
  output logic                      sa_valid,
  output logic                      irq
);
  localparam int SEL_W = $clog2(SA_NUM);
  localparam int FRM_W = $clog2(2 * SA_W);

  logic                           mfb_evt;
  logic                           sa_enabled;
  logic [SA_NUM-1:0][SA_W-1:0]    shadow;
  logic [SA_NUM*SA_W-1:0]         shadow_flat;

  assign sa_enabled  = xfs_en && sa_access_en;
  assign shadow_flat = shadow;

  sa_frame_ctr #(.FRM_W(FRM_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .strobe(frame_strobe),
    .frame_num(frame_num), .mf_begin(mfb_evt)
  );

  sa_regfile #(.N(SA_NUM), .W(SA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .copy(mfb_evt), .shadow_q(shadow)
  );

  sa_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(mfb_evt && sa_enabled),
    .clr(irq_clr), .flag(irq)
  );

  sa_bit_mux #(.N(SA_NUM), .W(SA_W), .FRM_W(FRM_W), .POS_W(POS_W)) u_mux (
    .shadow(shadow), .frame_num(frame_num), .sa_pos(sa_pos),
    .active(sa_enabled && !ts0_transp), .sa_bit(sa_bit), .sa_valid(sa_valid)
  );
endmodule

// File: rtl/sa_tx_checker.sv
module sa_tx_checker #(
  parameter int FRM_W = 4,
  parameter int SH_W  = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_strobe,
  input logic             irq_clr,
  input logic             xfs_en,
  input logic             sa_access_en,
  input logic             ts0_transp,
  input logic             sa_valid,
  input logic             sa_bit,
  input logic             irq,
  input logic [FRM_W-1:0] frame_num,
  input logic             mfb_evt,
  input logic [SH_W-1:0]  shadow_flat
);
  assert_valid_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sa_valid |-> frame_num[0]);
  assert_bit_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sa_bit |-> sa_valid);
  assert_valid_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sa_valid |-> (xfs_en && sa_access_en && !ts0_transp));
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mfb_evt && xfs_en && sa_access_en) |=> irq);
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  assert_frame_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> frame_num == FRM_W'($past(frame_num) + 1'b1));
  assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(frame_num));
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mfb_evt |=> $stable(shadow_flat));
endmodule

bind sa_tx_buffer sa_tx_checker #(.FRM_W(FRM_W), .SH_W(SA_NUM*SA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .irq_clr(irq_clr),
  .xfs_en(xfs_en), .sa_access_en(sa_access_en), .ts0_transp(ts0_transp),
  .sa_valid(sa_valid), .sa_bit(sa_bit), .irq(irq), .frame_num(frame_num),
  .mfb_evt(mfb_evt), .shadow_flat(shadow_flat)
);

// File: tb/test_sa_tx_buffer.sv
module test_sa_tx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       irq_clr = 1'b0;
  logic       xfs_en = 1'b0;
  logic       sa_access_en = 1'b0;
  logic       ts0_transp = 1'b0;
  logic       frame_strobe = 1'b0;
  logic [3:0] sa_pos = '0;
  logic [3:0] frame_num;
  logic       sa_bit;
  logic       sa_valid;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_host [5];
  logic [7:0] m_shad [5];
  int         m_frame;
  logic       m_irq;

  always #4 clk = ~clk;

  sa_tx_buffer i_sa_tx_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_clr(irq_clr), .xfs_en(xfs_en), .sa_access_en(sa_access_en),
    .ts0_transp(ts0_transp), .frame_strobe(frame_strobe), .sa_pos(sa_pos),
    .frame_num(frame_num), .sa_bit(sa_bit), .sa_valid(sa_valid), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (frame %0d pos %0d)",
               req, act, exp, m_frame, sa_pos);
    end
  endtask

  // one clock: apply inputs at a falling edge, update the model as of the rising edge
  task automatic cycle(input bit strobe, input bit wr, input int sel,
                       input logic [7:0] data, input bit clr);
    frame_strobe = strobe; wr_en = wr; wr_sel = sel[2:0]; wr_data = data; irq_clr = clr;
    @(negedge clk);
    frame_strobe = 0; wr_en = 0; irq_clr = 0;
    if (wr && sel < 5) m_host[sel] = data;
    if (strobe) begin
      if (m_frame == 15) begin
        for (int j = 0; j < 5; j++) m_shad[j] = m_host[j];
        if (xfs_en && sa_access_en) m_irq = 1;
        else if (clr) m_irq = 0;
      end else if (clr) m_irq = 0;
      m_frame = (m_frame + 1) % 16;
    end else if (clr) m_irq = 0;
  endtask

  // sweep every timeslot-0 position in the current frame
  task automatic sweep();
    logic on;
    int   e_bit;
    on = xfs_en && sa_access_en && !ts0_transp;
    chk("R10 frame_num", frame_num, m_frame);
    chk("R8 irq", irq, m_irq);
    for (int p = 0; p < 16; p++) begin
      sa_pos = p[3:0];
      #1;
      if (on && (m_frame % 2 == 1) && p >= 4 && p <= 8) begin
        e_bit = m_shad[p - 4][(m_frame - 1) / 2];
        chk("R5 sa_valid", sa_valid, 1);
        chk("R5 sa_bit", sa_bit, e_bit);
      end else begin
        chk((m_frame % 2 == 0 || p < 4 || p > 8) ? "R6 sa_valid" : "R7 sa_valid",
            sa_valid, 0);
        chk("R6 R7 sa_bit", sa_bit, 0);
      end
    end
  endtask

  task automatic run_mf(input bit new_data, input logic [7:0] seed);
    for (int f = 0; f < 16; f++) begin
      cycle(1, 0, 0, 8'h00, 0);
      sweep();
      if (new_data && f == 5)
        for (int j = 0; j < 5; j++) begin
          cycle(0, 1, j, seed ^ 8'(j * 37), 0);
          sweep();
        end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 5; j++) begin m_host[j] = 0; m_shad[j] = 0; end
    m_frame = 15; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    xfs_en = 1; sa_access_en = 1;
    // R1: reset state
    chk("R1 frame_num", frame_num, 15);
    chk("R1 irq", irq, 0);
    sweep();
    // R1: first multiframe carries the reset shadow (zeros); writes during it are R3
    run_mf(1, 8'hA5);
    // R3: new contents only appear now; R2: select 5..7 ignored
    cycle(0, 1, 5, 8'hFF, 0); cycle(0, 1, 6, 8'hFF, 0); cycle(0, 1, 7, 8'hFF, 0);
    run_mf(1, 8'h3C);
    // R8: clear the flag, then a clear coincident with the multiframe begin
    cycle(0, 0, 0, 8'h00, 1);
    chk("R8 irq cleared", irq, 0);
    for (int f = 0; f < 16; f++) begin
      cycle(1, 0, 0, 8'h00, f == 0);
      sweep();
    end
    // R9: no writes -> same bits again
    run_mf(0, 8'h00);
    // R4: write in the same cycle as the multiframe begin
    cycle(1, 1, 2, 8'hC3, 1);
    chk("R4 irq set wins R8", irq, 1);
    sweep();
    for (int f = 1; f < 16; f++) begin cycle(1, 0, 0, 8'h00, 0); sweep(); end
    // R7: every combination of enables and transparent mode
    for (int c = 0; c < 8; c++) begin
      xfs_en = c[0]; sa_access_en = c[1]; ts0_transp = c[2];
      cycle(0, 0, 0, 8'h00, 1);
      cycle(0, 1, c % 5, 8'(c * 29 + 1), 0);
      run_mf(0, 8'h00);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule